// File: doc/BRIEF.md
# Branch Colour Prefetch Filter

This block sits between an instruction prefetch queue and the decode stage. Every word that arrives from fetch carries its instruction, the address it was fetched from, and a one-bit stream colour. The filter keeps a local colour. Words whose colour matches it pass to decode with their own PC. Words whose colour differs are consumed and thrown away. The filter never counts how many words are in flight, because that number varies.

When execute reports a taken branch, the filter flips its local colour. It also raises a redirect to the fetch unit, carrying the branch target and the new colour. The fetch unit stamps every later word with that new colour. The redirect is held back while the prefetch queue reports itself full, which avoids the full-pipe deadlock. Only one redirect is outstanding at a time: execute sees its branch input stalled until the fetch unit takes the pending redirect.

Back-pressure rules:
- Fetch input: a matching word is taken when the decode register is empty or is being drained. A stale word is always taken.
- Decode output: data stays stable while valid is high and ready is low. The one exception is a taken branch, which empties the decode register.

Top module: `colour_prefetch_filter`

## Requirements
- R1: After reset the local colour is 0 and the decode output is empty. A redirect is pending with target RESET_VEC and colour 0, and branch_ready is low.
- R2: A branch handshake (br_valid and br_ready both high at a clock edge) flips the local colour. From the next cycle, rd_target shows the branch target and rd_colour shows the new colour.
- R3: A fetch word with f_colour different from the local colour gets f_ready high and never appears on the decode output.
- R4: A fetch word with f_colour equal to the local colour, taken while no branch handshake happens, appears on d_insn/d_pc with d_valid one cycle later. Words keep their order and each keeps its own PC.
- R5: While d_valid is high and d_ready is low, d_valid, d_insn and d_pc hold at the next edge, unless a branch handshake occurs. For a matching word, f_ready equals !d_valid or d_ready.
- R6: rd_valid is low whenever pq_full is high. A pending redirect stays pending, with the same target and colour, until it is taken with rd_valid and rd_ready both high.
- R7: br_ready is high exactly when no redirect is pending. A redirect is taken in a single cycle.
- R8: A branch handshake empties the decode output at that edge. Any fetch word offered in the same cycle is consumed (f_ready high) and dropped.
- R9: A second branch accepted after the first redirect was taken, but before any word of the new colour arrived, flips the colour back. Words stamped with the first new colour then count as stale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_valid | input | 1 | Fetch word valid |
| f_ready | output | 1 | Filter takes the fetch word |
| f_insn | input | IW | Fetched instruction |
| f_pc | input | AW | Address the word was fetched from |
| f_colour | input | 1 | Stream colour stamped by fetch |
| br_valid | input | 1 | Taken-branch request from execute |
| br_ready | output | 1 | Branch request accepted |
| br_target | input | AW | Branch target address |
| pq_full | input | 1 | Prefetch queue full; blocks redirect issue |
| rd_valid | output | 1 | Redirect request to fetch |
| rd_ready | input | 1 | Fetch takes the redirect |
| rd_target | output | AW | Start address of the new stream |
| rd_colour | output | 1 | Colour fetch must stamp on the new stream |
| d_valid | output | 1 | Decode word valid |
| d_ready | input | 1 | Decode takes the word |
| d_insn | output | IW | Instruction to decode |
| d_pc | output | AW | PC of that instruction |

## Verification
f_ready, br_ready and rd_valid are combinational. The bench checks them one time unit after it drives each cycle's inputs, well before the edge.

The decode register, rd_target and rd_colour change one edge after the handshake that causes them. The bench checks these 2 ns after that edge, against a model it updated from the inputs of the cycle just closed.

Random traffic (stale runs of varying length, branch bursts, full-queue stalls, decode stalls) is preceded by directed reset and full-queue checks.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
  typedef logic colour_t;

  function automatic logic word_is_stale(input colour_t stamp, input colour_t local_col);
    return stamp != local_col;
  endfunction
endpackage

// File: rtl/cpf_steer.sv
module cpf_steer #(
  parameter int AW = 32,
  parameter logic [AW-1:0] RESET_VEC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          br_valid,
  input  logic [AW-1:0] br_target,
  output logic          br_ready,
  output logic          br_take,
  input  logic          pq_full,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [AW-1:0] rd_target,
  output cpf_pkg::colour_t rd_colour,
  output cpf_pkg::colour_t colour
);
  logic pending;

  assign br_ready = !pending;
  assign br_take  = br_valid && br_ready;
  assign rd_valid = pending && !pq_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      colour    <= 1'b0;
      pending   <= 1'b1;
      rd_target <= RESET_VEC;
      rd_colour <= 1'b0;
    end else if (br_take) begin
      colour    <= !colour;
      pending   <= 1'b1;
      rd_target <= br_target;
      rd_colour <= !colour;
    end else if (rd_valid && rd_ready) begin
      pending   <= 1'b0;
    end
  end
endmodule

// File: rtl/cpf_outreg.sv
module cpf_outreg #(
  parameter int IW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          flush,
  input  logic [IW-1:0] in_insn,
  input  logic [AW-1:0] in_pc,
  input  logic          d_ready,
  output logic          d_valid,
  output logic [IW-1:0] d_insn,
  output logic [AW-1:0] d_pc,
  output logic          has_room
);
  assign has_room = !d_valid || d_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d_valid <= 1'b0;
      d_insn  <= '0;
      d_pc    <= '0;
    end else if (flush) begin
      d_valid <= 1'b0;
    end else if (load) begin
      d_valid <= 1'b1;
      d_insn  <= in_insn;
      d_pc    <= in_pc;
    end else if (d_ready) begin
      d_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/colour_prefetch_filter.sv
module colour_prefetch_filter #(
  parameter int IW = 32,
  parameter int AW = 32,
  parameter logic [AW-1:0] RESET_VEC = 32'h0000_0100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          f_valid,
  output logic          f_ready,
  input  logic [IW-1:0] f_insn,
  input  logic [AW-1:0] f_pc,
  input  logic          f_colour,
  input  logic          br_valid,
  output logic          br_ready,
  input  logic [AW-1:0] br_target,
  input  logic          pq_full,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_target,
  output logic          rd_colour,
  output logic          d_valid,
  input  logic          d_ready,
  output logic [IW-1:0] d_insn,
  output logic [AW-1:0] d_pc
);
  import cpf_pkg::*;

  colour_t colour;
  logic    br_take;
  logic    has_room;
  logic    drop;
  logic    load;

  cpf_steer #(.AW(AW), .RESET_VEC(RESET_VEC)) u_steer (
    .clk(clk), .rst_n(rst_n),
    .br_valid(br_valid), .br_target(br_target), .br_ready(br_ready), .br_take(br_take),
    .pq_full(pq_full), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_target(rd_target), .rd_colour(rd_colour), .colour(colour)
  );

  // A stale stamp or a branch in this cycle makes the offered word disposable.
  assign drop    = word_is_stale(f_colour, colour) || br_take;
  assign f_ready = drop || has_room;
  assign load    = f_valid && !drop && has_room;

  cpf_outreg #(.IW(IW), .AW(AW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .load(load), .flush(br_take), .in_insn(f_insn), .in_pc(f_pc),
    .d_ready(d_ready), .d_valid(d_valid), .d_insn(d_insn), .d_pc(d_pc),
    .has_room(has_room)
  );
endmodule

// File: rtl/cpf_checker.sv
module cpf_checker #(
  parameter int IW = 32,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          colour,
  input logic          f_valid,
  input logic          f_ready,
  input logic          f_colour,
  input logic          br_valid,
  input logic          br_ready,
  input logic          pq_full,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_target,
  input logic          rd_colour,
  input logic          d_valid,
  input logic          d_ready,
  input logic [IW-1:0] d_insn,
  input logic [AW-1:0] d_pc
);
  a_r2_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_ready) |=> (colour != $past(colour)) && (rd_colour == colour));

  a_r3_stale_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (f_valid && (f_colour != colour)) |-> f_ready);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && !d_ready && !(br_valid && br_ready)) |=> d_valid && $stable(d_insn) && $stable(d_pc));

  a_r6_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    pq_full |-> !rd_valid);

  a_r6_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_ready && !(rd_valid && rd_ready)) |=> !br_ready && $stable(rd_target) && $stable(rd_colour));

  a_r7_one_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_ready) |=> !br_ready);

  a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_ready) |=> !d_valid);
endmodule

bind colour_prefetch_filter cpf_checker #(.IW(IW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .colour(colour),
  .f_valid(f_valid), .f_ready(f_ready), .f_colour(f_colour),
  .br_valid(br_valid), .br_ready(br_ready), .pq_full(pq_full),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_target(rd_target), .rd_colour(rd_colour),
  .d_valid(d_valid), .d_ready(d_ready), .d_insn(d_insn), .d_pc(d_pc)
);

// File: tb/sim_colour_prefetch_filter.sv
module sim_colour_prefetch_filter;
  localparam int IW = 32;
  localparam int AW = 32;
  localparam logic [AW-1:0] RV = 32'h0000_0100;

  logic clk = 0, rst_n = 0;
  logic f_valid = 0, f_colour = 0, br_valid = 0, pq_full = 0, rd_ready = 0, d_ready = 0;
  logic [IW-1:0] f_insn = '0;
  logic [AW-1:0] f_pc = '0, br_target = '0;
  logic f_ready, br_ready, rd_valid, rd_colour, d_valid;
  logic [AW-1:0] rd_target, d_pc;
  logic [IW-1:0] d_insn;

  int checks = 0, fails = 0;
  logic m_col, m_pend, m_rcol, m_dv;
  logic [AW-1:0] m_tgt, m_dpc;
  logic [IW-1:0] m_di;

  always #10 clk = !clk;

  colour_prefetch_filter #(.IW(IW), .AW(AW), .RESET_VEC(RV)) u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_fready();
    return (f_colour != m_col) || (br_valid && !m_pend) || !m_dv || d_ready;
  endfunction

  task automatic check_regs();
    chk(d_valid === m_dv, m_dv ? "R4" : "R8", "d_valid", 64'(d_valid), 64'(m_dv));
    if (m_dv) begin
      chk(d_insn === m_di, "R4", "d_insn", 64'(d_insn), 64'(m_di));
      chk(d_pc === m_dpc, "R4", "d_pc", 64'(d_pc), 64'(m_dpc));
    end
    if (m_pend) begin
      chk(rd_target === m_tgt, "R2", "rd_target", 64'(rd_target), 64'(m_tgt));
      chk(rd_colour === m_rcol, "R9", "rd_colour", 64'(rd_colour), 64'(m_rcol));
    end
  endtask

  task automatic check_comb_and_step();
    logic br_acc, rd_fire, drop, ld;
    #1;
    chk(br_ready === !m_pend, "R7", "br_ready", 64'(br_ready), 64'(!m_pend));
    chk(rd_valid === (m_pend && !pq_full), "R6", "rd_valid", 64'(rd_valid), 64'(m_pend && !pq_full));
    if (f_valid)
      chk(f_ready === exp_fready(), (f_colour != m_col) ? "R3" : "R5", "f_ready",
          64'(f_ready), 64'(exp_fready()));
    br_acc  = br_valid && !m_pend;
    rd_fire = m_pend && !pq_full && rd_ready;
    drop    = (f_colour != m_col) || br_acc;
    ld      = f_valid && !drop && (!m_dv || d_ready);
    if (br_acc) begin
      m_rcol = !m_col; m_col = !m_col; m_pend = 1; m_tgt = br_target; m_dv = 0;
    end else begin
      if (rd_fire) m_pend = 0;
      if (ld) begin m_dv = 1; m_di = f_insn; m_dpc = f_pc; end
      else if (d_ready) m_dv = 0;
    end
    @(posedge clk); #2;
    check_regs();
  endtask

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    m_col = 0; m_pend = 1; m_rcol = 0; m_tgt = RV; m_dv = 0; m_di = '0; m_dpc = '0;
    // R1: reset state
    chk(d_valid === 1'b0, "R1", "d_valid", 64'(d_valid), 0);
    chk(rd_target === RV, "R1", "rd_target", 64'(rd_target), 64'(RV));
    chk(rd_colour === 1'b0, "R1", "rd_colour", 64'(rd_colour), 0);
    chk(br_ready === 1'b0, "R1", "br_ready", 64'(br_ready), 0);
    // R6: full queue holds the reset redirect back
    pq_full = 1; rd_ready = 1;
    repeat (3) check_comb_and_step();
    pq_full = 0;
    check_comb_and_step();
    rd_ready = 0;
    // R9: two branches back to back, stale words of the middle colour
    br_valid = 1; br_target = 32'h2000;
    check_comb_and_step();
    br_valid = 0; rd_ready = 1;
    check_comb_and_step();
    rd_ready = 0; br_valid = 1; br_target = 32'h3000;
    check_comb_and_step();
    br_valid = 0; f_valid = 1; f_colour = 1; f_insn = 32'hdead; f_pc = 32'h2000; d_ready = 1;
    repeat (3) check_comb_and_step();
    f_colour = 0; f_insn = 32'h1111; f_pc = 32'h3000;
    check_comb_and_step();
    f_valid = 0;
    check_comb_and_step();
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      f_valid   = ($urandom % 10) < 7;
      f_colour  = (($urandom % 100) < 65) ? m_col : !m_col;
      f_insn    = $urandom;
      f_pc      = $urandom & 32'hffff_fffc;
      br_valid  = ($urandom % 100) < 8;
      br_target = $urandom & 32'hffff_fffc;
      pq_full   = ($urandom % 4) == 0;
      rd_ready  = $urandom % 2;
      d_ready   = ($urandom % 10) < 6;
      check_comb_and_step();
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule